// File: doc/BRIEF.md
# Character Relay Queue

This block passes characters from an input device to an output device through a small wraparound queue, so the two devices can run at different rates. Each time the input device signals that a byte is ready, the block stores that byte. If there is no room, it drops the byte and raises a sticky error. In both cases it then returns a one-cycle acknowledge, which clears the input status so the next transfer can begin.

On the output side, the block keeps a data register and a busy status. Whenever the output is idle, or finishes a character, and a character is waiting, the block loads the oldest waiting character and marks the output busy. A byte that arrives while the queue is empty and the output is idle goes straight out on the next cycle. The output stays busy until the device returns a done strobe.

The queue always leaves one slot unused, so that a full queue can be told apart from an empty one. With the default depth of 8, at most 7 characters wait at a time. The current occupancy is available on a port.

Top module: `char_relay_queue`

## Requirements
- R1: A synchronous active-high reset clears the queue pointers, the error flag, the busy status and the acknowledge. After reset `fill` is 0, `out_busy` is 0, `err` is 0 and `in_ack` is 0.
- R2: Suppose the queue is empty and the output is idle (`out_busy` 0) when `in_valid` is sampled high. On the next cycle `out_busy` is 1, `out_byte` equals that `in_byte`, and `fill` stays 0.
- R3: The queue holds at most DEPTH-1 characters. Suppose `in_valid` is high while `fill` equals DEPTH-1. The byte is dropped, `fill` does not grow, and `err` reads 1 on the next cycle.
- R4: Once `err` is 1, it stays 1 until reset.
- R5: `in_ack` is high for exactly the cycle that follows each cycle in which `in_valid` was high, whether the byte was stored or dropped.
- R6: Suppose `out_done` is high while busy and characters are waiting. On the next cycle `out_byte` holds the oldest waiting character, `out_busy` stays 1, and `fill` drops by one. Characters leave in the order they arrived.
- R7: Suppose `out_done` is high while busy, the queue is empty and no byte arrives in that cycle. On the next cycle `out_busy` is 0.
- R8: While `out_busy` is 1 and `out_done` is low, `out_busy` stays 1 and `out_byte` does not change. No character is launched in that state.
- R9: An accepted input and an `out_done` in the same cycle are both carried out. With characters already waiting, `fill` is unchanged afterwards.
- R10: `fill` equals the number of waiting characters. It is tail minus head when head is at or below tail, and DEPTH plus tail minus head otherwise, correct across pointer wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input device has a byte ready (one event per high cycle) |
| in_byte | input | W | Byte from the input device |
| in_ack | output | 1 | Clears the input status, one cycle after each event |
| out_done | input | 1 | Output device finished the current character |
| out_byte | output | W | Output data register |
| out_busy | output | 1 | Output status: 1 while a transfer is in progress |
| err | output | 1 | Sticky overflow flag |
| fill | output | $clog2(DEPTH+1) | Number of characters waiting |

## Verification
The bench drives the queue to exactly DEPTH-1 entries and then pushes once more. A design that used every slot would report a full queue as empty and lose characters, and a design that stored the extra byte would overwrite the oldest entry.

It pushes into an empty queue while the output is idle, to confirm that the byte goes out at once. A design without that bypass would leave the character stranded with the output idle.

It applies input and done together, both with the queue full and with the queue partly filled. A design that let one event shadow the other would lose a byte or miscount `fill`.

It also raises done on an empty queue and runs long random traffic through many pointer wraps. This catches busy stuck high, order reversal and occupancy errors at the wrap point.

// File: rtl/char_relay_queue.sv
module char_relay_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [W-1:0]               in_byte,
  output logic                       in_ack,
  input  logic                       out_done,
  output logic [W-1:0]               out_byte,
  output logic                       out_busy,
  output logic                       err,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic          empty, full, push, pop, launch_ok;
  logic [W-1:0]  pop_data;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (head == tail);
  assign full      = (bump(tail) == head);
  assign push      = in_valid && !full;
  assign launch_ok = !out_busy || out_done;
  assign pop       = launch_ok && (!empty || push);
  assign pop_data  = empty ? in_byte : mem[head];

  assign fill = (head <= tail) ? CW'(tail) - CW'(head)
                               : CW'(DEPTH) + CW'(tail) - CW'(head);

  always_ff @(posedge clk)
    if (push) mem[tail] <= in_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      err      <= 1'b0;
      in_ack   <= 1'b0;
      out_busy <= 1'b0;
      out_byte <= '0;
    end else begin
      in_ack <= in_valid;
      if (in_valid && full) err <= 1'b1;
      if (push) tail <= bump(tail);
      if (pop) begin
        head     <= bump(head);
        out_byte <= pop_data;
        out_busy <= 1'b1;
      end else if (out_done) begin
        out_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/char_relay_queue_chk.sv
module char_relay_queue_chk #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [W-1:0]               in_byte,
  input logic                       in_ack,
  input logic                       out_done,
  input logic [W-1:0]               out_byte,
  input logic                       out_busy,
  input logic                       err,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  p_fill_cap_r3: assert property (@(posedge clk) disable iff (rst)
    fill <= ($clog2(DEPTH+1))'(DEPTH-1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill == ($clog2(DEPTH+1))'(DEPTH-1)) |=> err);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_ack_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> in_ack);

  p_ack_only_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !in_ack);

  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (!out_busy && fill == '0 && in_valid) |=> (out_busy && out_byte == $past(in_byte) && fill == '0));

  p_drain_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (out_busy && out_done && fill == '0 && !in_valid) |=> !out_busy);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_busy && !out_done) |=> (out_busy && $stable(out_byte)));
endmodule

bind char_relay_queue char_relay_queue_chk #(.DEPTH(DEPTH), .W(W)) chk_i (.*);

// File: tb/char_relay_queue_tb_top.sv
module char_relay_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int W = 8;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_done = 1'b0;
  logic [W-1:0] in_byte = '0;
  logic in_ack, out_busy, err;
  logic [W-1:0] out_byte;
  logic [CW-1:0] fill;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [W-1:0] mq[$];
  logic m_busy = 0, m_err = 0, m_ack = 0;
  logic [W-1:0] m_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_relay_queue #(.DEPTH(DEPTH), .W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ack(in_ack),
    .out_done(out_done), .out_byte(out_byte), .out_busy(out_busy), .err(err), .fill(fill));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    mq.delete(); m_busy = 0; m_err = 0; m_ack = 0; m_byte = '0;
  endfunction

  function automatic void model_step(logic v, logic [W-1:0] b, logic d);
    bit full_now = (mq.size() == DEPTH-1);
    bit can_launch = !m_busy || d;
    m_ack = v;
    if (v && full_now) m_err = 1;
    if (v && !full_now) mq.push_back(b);
    if (can_launch && mq.size() > 0) begin
      m_byte = mq.pop_front();
      m_busy = 1;
    end else if (d) m_busy = 0;
  endfunction

  task automatic step(logic v, logic [W-1:0] b, logic d);
    in_valid = v; in_byte = b; out_done = d;
    @(posedge clk);
    model_step(v, b, d);
    #1;
    check("R8 busy", int'(out_busy), int'(m_busy));
    if (m_busy) check("R6 out_byte", int'(out_byte), int'(m_byte));
    check("R10 fill", int'(fill), mq.size());
    check("R4 err", int'(err), int'(m_err));
    check("R5 ack", int'(in_ack), int'(m_ack));
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; out_done = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    model_reset();
    check("R1 fill", int'(fill), 0);
    check("R1 busy", int'(out_busy), 0);
    check("R1 err", int'(err), 0);
    check("R1 ack", int'(in_ack), 0);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    do_reset();

    step(1, 8'h41, 0);
    check("R2 bypass busy", int'(out_busy), 1);
    check("R2 bypass byte", int'(out_byte), 8'h41);
    check("R2 bypass fill", int'(fill), 0);

    for (int i = 0; i < DEPTH-1; i++) step(1, W'(8'h50 + i), 0);
    check("R3 full fill", int'(fill), DEPTH-1);
    check("R3 err before", int'(err), 0);
    step(1, 8'hEE, 0);
    check("R3 dropped fill", int'(fill), DEPTH-1);
    check("R3 err set", int'(err), 1);

    step(0, 0, 0);
    check("R8 hold byte", int'(out_byte), 8'h41);

    step(1, 8'hEF, 1);
    check("R6 next byte", int'(out_byte), 8'h50);
    check("R6 fill dec", int'(fill), DEPTH-2);

    step(1, 8'h60, 1);
    check("R9 fill same", int'(fill), DEPTH-2);
    check("R9 byte", int'(out_byte), 8'h51);

    for (int i = 0; i < DEPTH-2; i++) step(0, 0, 1);
    check("R6 order last", int'(out_byte), 8'h60);
    check("R4 err held", int'(err), 1);
    step(0, 0, 1);
    check("R7 idle", int'(out_busy), 0);
    step(0, 0, 1);
    check("R7 stays idle", int'(out_busy), 0);

    do_reset();
    check("R4 cleared by reset", int'(err), 0);

    for (int n = 0; n < 4000; n++) begin
      logic v = ($urandom_range(99) < 45);
      logic d = ($urandom_range(99) < 40);
      step(v, W'($urandom), d);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule